// File: doc/BRIEF.md
# Change-Compressed Sample Packer with Cluster Timestamps

This block turns a stream of 16-bit pin samples into a compact record for a row-organised sample memory. A sample tick is marked by `tick_en`. A free-running tick counter supplies the timestamps. A sample is written only when the pin levels differ from the last stored sample. Stored samples are grouped into clusters of eight words: one timestamp word, then up to seven event words. The first event belongs to the timestamp's tick, and each later event belongs to the tick right after the one before it.

A change that cannot be appended to the open cluster closes that cluster. The block pads the unused slots with the last stored sample and opens a new cluster with a fresh timestamp. A new cluster is also forced whenever the tick counter has wrapped to zero. Words leave the block as address/data write requests. The address is a position whose upper bits are a row and whose lower bits are a word within the row. By default there are 32768 rows of 512 words, which is 64 clusters or 448 events per row.

When the position passes the last row, a round flag is set and writing continues at row 0. A stop request pads and closes the open cluster and then reports the final position. Ticks must be at least 9 clocks apart, so that the up to eight words one tick can produce are all emitted before the next tick arrives.

FSM states:

| State | Role |
|---|---|
| PK_IDLE | Wait for a tick or a stop. |
| PK_PAD | Emit padding words. |
| PK_STAMP | Emit the timestamp word. |
| PK_EVENT | Emit the event word. |
| PK_DONE | Stopped. |

FSM transitions:

| From | Condition | To |
|---|---|---|
| PK_IDLE | stop with an open cluster | PK_PAD |
| PK_IDLE | stop with no open cluster | PK_DONE |
| PK_IDLE | appendable change | PK_EVENT |
| PK_IDLE | other change with an open cluster | PK_PAD |
| PK_IDLE | other change with no open cluster | PK_STAMP |
| PK_PAD | last padding word | PK_STAMP, or PK_DONE when flushing |
| PK_STAMP | always | PK_EVENT |
| PK_EVENT | always | PK_IDLE |

A stop request has priority over a tick in the same cycle.

Top module: `change_packer`

## Requirements
- R1: A new cluster writes its timestamp word and then the changed sample as its first event. The timestamp word is the tick number, zero-extended to 16 bits.
- R2: A change on the tick right after the open cluster's last event tick is appended as a single event word. The new cluster rules still apply on a tick whose number is zero.
- R3: A tick whose sample equals the last stored sample produces no write. This does not apply to the first tick after reset or to a tick numbered zero.
- R4: A tick numbered zero (the counter has wrapped) always closes the open cluster and starts a new one, even if the sample is unchanged.
- R5: A change that cannot be appended closes the open cluster. Its remaining event slots are filled with the last stored sample before the new timestamp is written.
- R6: A cluster holding seven events is closed without padding. The next change starts a new cluster.
- R7: Each write uses the current position as its address, and the position then advances by one. The position is {row, word}, with the word index in the low WORD_BITS bits. Clusters never straddle rows.
- R8: When the position wraps from its maximum value to zero, `round_done` sets and stays set until reset.
- R9: A stop request pads the open cluster to eight words. It then raises `stop_done`, and `stop_pos` shows the position after the last write.
- R10: After the stop, ticks and sample changes cause no writes, and the position stays fixed.
- R11: After reset there are no writes, the position is zero, and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Sample tick strobe |
| sample_in | input | 16 | Pin levels for this tick |
| stop_req | input | 1 | Stop and flush request |
| wr_en | output | 1 | Memory write request |
| wr_addr | output | ROW_BITS+WORD_BITS | Write position (row, word) |
| wr_data | output | 16 | Word to write |
| wr_pos | output | ROW_BITS+WORD_BITS | Next write position |
| round_done | output | 1 | Position wrapped at least once |
| stop_done | output | 1 | Stopped after flush |
| stop_pos | output | ROW_BITS+WORD_BITS | Final position, valid with stop_done |

## Verification
A wrong open-cluster count or stale stored sample shows up at the next change, no more than eight clocks after that tick. It appears as a missing or extra padding word, or a wrong event value at a given address. A wrong position or round flag is visible on the very next write address. Because every written word is compared in order against an expected stream, one slip desynchronises every following address and is reported right away.

// File: rtl/pack_pkg.sv
package pack_pkg;
    localparam int EV_PER_CL = 7;

    typedef enum logic [2:0] {
        PK_IDLE,
        PK_PAD,
        PK_STAMP,
        PK_EVENT,
        PK_DONE
    } pk_state_t;
endpackage

// File: rtl/pack_tick_ctr.sv
module pack_tick_ctr #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    output logic [TS_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (step)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pack_pos_ctr.sv
module pack_pos_ctr #(
    parameter int POS_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [POS_W-1:0] pos,
    output logic             round
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos   <= '0;
            round <= 1'b0;
        end else if (adv) begin
            pos <= pos + 1'b1;
            if (&pos)
                round <= 1'b1;
        end
    end

    // R8
    round_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        round |=> round);
endmodule

// File: rtl/pack_change_det.sv
module pack_change_det #(
    parameter int DATA_W = 16,
    parameter int TS_W   = 16
) (
    input  logic [DATA_W-1:0] smp,
    input  logic [DATA_W-1:0] last,
    input  logic              first,
    input  logic [TS_W-1:0]   tick,
    input  logic              open,
    input  logic [TS_W-1:0]   ts,
    input  logic [2:0]        nev,
    output logic              chg,
    output logic              append
);
    logic [TS_W-1:0] nxt_tick;
    logic            wrap_tick;

    always_comb begin
        nxt_tick  = ts + TS_W'(nev);
        wrap_tick = (tick == '0);
        chg       = first || (smp != last) || wrap_tick;
        append    = open && !wrap_tick && (tick == nxt_tick);
    end
endmodule

// File: rtl/change_packer.sv
module change_packer
    import pack_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int TS_W      = 16,
    parameter int ROW_BITS  = 15,
    parameter int WORD_BITS = 9,
    localparam int POS_W    = ROW_BITS + WORD_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              stop_req,
    output logic              wr_en,
    output logic [POS_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [POS_W-1:0]  wr_pos,
    output logic              round_done,
    output logic              stop_done,
    output logic [POS_W-1:0]  stop_pos
);
    pk_state_t         state_q;
    logic [TS_W-1:0]   cnt;
    logic [TS_W-1:0]   ts_q, stamp_q;
    logic [DATA_W-1:0] last_q, smp_q;
    logic [2:0]        nev_q, pad_q;
    logic              open_q, first_q, flush_q;
    logic              chg, append;

    pack_tick_ctr #(.TS_W(TS_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .step (tick_en && state_q != PK_DONE),
        .cnt  (cnt)
    );

    pack_pos_ctr #(.POS_W(POS_W)) u_pos (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (wr_en),
        .pos  (wr_pos),
        .round(round_done)
    );

    pack_change_det #(.DATA_W(DATA_W), .TS_W(TS_W)) u_det (
        .smp   (sample_in),
        .last  (last_q),
        .first (first_q),
        .tick  (cnt),
        .open  (open_q),
        .ts    (ts_q),
        .nev   (nev_q),
        .chg   (chg),
        .append(append)
    );

    // State register and cluster bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PK_IDLE;
            ts_q    <= '0;
            stamp_q <= '0;
            last_q  <= '0;
            smp_q   <= '0;
            nev_q   <= '0;
            pad_q   <= '0;
            open_q  <= 1'b0;
            first_q <= 1'b1;
            flush_q <= 1'b0;
        end else begin
            unique case (state_q)
                PK_IDLE: begin
                    if (stop_req) begin
                        flush_q <= 1'b1;
                        if (open_q) begin
                            pad_q   <= 3'(EV_PER_CL) - nev_q;
                            state_q <= PK_PAD;
                        end else begin
                            state_q <= PK_DONE;
                        end
                    end else if (tick_en && chg) begin
                        smp_q <= sample_in;
                        if (append) begin
                            state_q <= PK_EVENT;
                        end else begin
                            stamp_q <= cnt;
                            if (open_q) begin
                                pad_q   <= 3'(EV_PER_CL) - nev_q;
                                state_q <= PK_PAD;
                            end else begin
                                state_q <= PK_STAMP;
                            end
                        end
                    end
                end
                PK_PAD: begin
                    pad_q <= pad_q - 1'b1;
                    if (pad_q == 3'd1) begin
                        open_q  <= 1'b0;
                        state_q <= flush_q ? PK_DONE : PK_STAMP;
                    end
                end
                PK_STAMP: begin
                    ts_q    <= stamp_q;
                    nev_q   <= '0;
                    open_q  <= 1'b1;
                    state_q <= PK_EVENT;
                end
                PK_EVENT: begin
                    nev_q   <= nev_q + 1'b1;
                    last_q  <= smp_q;
                    first_q <= 1'b0;
                    if (nev_q == 3'(EV_PER_CL - 1))
                        open_q <= 1'b0;
                    state_q <= PK_IDLE;
                end
                PK_DONE: state_q <= PK_DONE;
                default: state_q <= PK_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        wr_en   = 1'b0;
        wr_data = '0;
        unique case (state_q)
            PK_PAD:   begin wr_en = 1'b1; wr_data = last_q; end
            PK_STAMP: begin wr_en = 1'b1; wr_data = DATA_W'(stamp_q); end
            PK_EVENT: begin wr_en = 1'b1; wr_data = smp_q; end
            default:  begin wr_en = 1'b0; wr_data = '0; end
        endcase
        wr_addr   = wr_pos;
        stop_done = (state_q == PK_DONE);
        stop_pos  = stop_done ? wr_pos : '0;
    end

    // R1
    stamp_then_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PK_STAMP) |=> (wr_en && state_q == PK_EVENT));

    // R3
    no_change_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PK_IDLE && tick_en && !stop_req && !first_q &&
         sample_in == last_q && cnt != '0) |=> !wr_en);

    // R6
    nev_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |-> (nev_q < 3'(EV_PER_CL)));

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done |=> (!wr_en && $stable(wr_pos) && stop_done));
endmodule

// File: tb/test_change_packer.sv
module test_change_packer;
    localparam int TS_W = 5;
    localparam int RB   = 2;
    localparam int WB   = 4;
    localparam int PW   = RB + WB;
    localparam int TMOD = 1 << TS_W;
    localparam int PMOD = 1 << PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic [15:0]   sample_in = '0;
    logic          stop_req = 1'b0;
    logic          wr_en;
    logic [PW-1:0] wr_addr, wr_pos, stop_pos;
    logic [15:0]   wr_data;
    logic          round_done, stop_done;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    change_packer #(.TS_W(TS_W), .ROW_BITS(RB), .WORD_BITS(WB)) i_change_packer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sample_in(sample_in),
        .stop_req(stop_req), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_pos(wr_pos), .round_done(round_done), .stop_done(stop_done),
        .stop_pos(stop_pos)
    );

    // scoreboard
    int    q_addr[$];
    int    q_data[$];
    string q_tag[$];

    // reference model state
    int m_cnt = 0, m_ts = 0, m_nev = 0, m_pos = 0;
    int m_last = 0;
    bit m_open = 0, m_first = 1, m_round = 0;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input int d, input string tag);
        q_addr.push_back(m_pos);
        q_data.push_back(d);
        q_tag.push_back(tag);
        if (m_pos == PMOD - 1) m_round = 1;
        m_pos = (m_pos + 1) % PMOD;
    endtask

    task automatic model_tick(input int s);
        int t;
        t = m_cnt;
        m_cnt = (m_cnt + 1) % TMOD;
        if (!m_first && s == m_last && t != 0) return;
        if (m_open && t != 0 && t == (m_ts + m_nev) % TMOD) begin
            push(s, "R2");
            m_nev++;
            if (m_nev == 7) m_open = 0;
        end else begin
            if (m_open)
                for (int k = m_nev; k < 7; k++) push(m_last, "R5");
            push(t, (t == 0) ? "R4" : "R1");
            push(s, (t == 0) ? "R4" : "R1");
            m_ts = t; m_nev = 1; m_open = 1;
        end
        m_last = s;
        m_first = 0;
    endtask

    task automatic do_tick(input int s);
        @(negedge clk);
        tick_en = 1'b1;
        sample_in = 16'(s);
        if (!stop_done) model_tick(s);
        @(negedge clk);
        tick_en = 1'b0;
        repeat (9) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (q_addr.size() == 0) begin
                total++; bad++;
                $display("FAIL R3 actual=unexpected write %0d@%0d expected=no write",
                         wr_data, wr_addr);
            end else begin
                string tg;
                tg = q_tag.pop_front();
                check({tg, " data"}, int'(wr_data), q_data.pop_front());
                check("R7 addr", int'(wr_addr), q_addr.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 wr_en", int'(wr_en), 0);
        check("R11 pos", int'(wr_pos), 0);
        check("R11 round", int'(round_done), 0);
        check("R11 stop_done", int'(stop_done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2/R6: changing every tick fills full clusters
        for (int i = 0; i < 16; i++) do_tick(i * 3 + 1);
        // R3: unchanged run
        begin
            int p0;
            p0 = m_pos;
            for (int i = 0; i < 4; i++) do_tick(46);
            check("R3 pos hold", int'(wr_pos), p0);
        end
        // R5: sparse changes close partial clusters
        do_tick(100); do_tick(100); do_tick(101);
        do_tick(102); do_tick(102); do_tick(102); do_tick(7);
        // R4: long constant run crossing counter wrap
        for (int i = 0; i < 40; i++) do_tick(7);
        // more changes, alternating patterns
        for (int i = 0; i < 20; i++) do_tick((i % 3 == 0) ? 7 : 500 + i);
        // R8
        check("R8 round", int'(round_done), int'(m_round));
        check("R8 exercised", int'(m_round), 1);

        // R9 stop
        @(negedge clk);
        stop_req = 1'b1;
        if (m_open) for (int k = m_nev; k < 7; k++) push(m_last, "R9");
        m_open = 0;
        @(negedge clk);
        stop_req = 1'b0;
        repeat (12) @(negedge clk);
        check("R9 stop_done", int'(stop_done), 1);
        check("R9 stop_pos", int'(stop_pos), m_pos);
        check("R9 drained", q_addr.size(), 0);

        // R10 ignored after stop
        for (int i = 0; i < 5; i++) do_tick(900 + i);
        check("R10 pos", int'(wr_pos), m_pos);
        check("R10 stop_pos", int'(stop_pos), m_pos);
        check("R10 no writes", q_addr.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule